// File: doc/BRIEF.md
# Sequential Sixteen-Sample Averager

This block computes the arithmetic mean of sixteen unsigned 8-bit samples using one adder and one running-sum register. The samples are fed in one after another. A one-hot controller steers a small data path made of an accumulator and a sample counter. Division by sixteen costs no logic: the result is the top eight bits of the 12-bit sum, which is the sum shifted right by four and truncated.

A run begins when `start` is seen high while the block is idle. The controller clears the sum and the counter, then repeats a four-step loop: capture, settle, acknowledge, advance. The source watches `sample_taken` and presents the next sample after each pulse. After the sixteenth sample has been added, the mean is loaded into the output register and `mean_valid` pulses for one cycle. The block then returns to idle. The output register keeps its value until the next run completes.

Top module: `seq_averager`

## Requirements
- R1: A synchronous reset, asserted at any point (including in the middle of a run), abandons any run and leaves `mean_out` = 0, `mean_valid` = 0 and `sample_taken` = 0.
- R2: The reported mean is bits [11:4] of the 12-bit sum of the sixteen samples. This is floor(sum/16), with no rounding.
- R3: Each run accumulates exactly sixteen samples, and `sample_taken` pulses exactly sixteen times per run. The first sample is captured on the second clock edge after the edge that samples `start`. Each later sample is captured on the second edge after the preceding `sample_taken` pulse.
- R4: `mean_valid` rises on the 64th clock edge after the edge that samples `start`.
- R5: `mean_valid` is high for exactly one cycle. After it, the block is idle and raises no `sample_taken` until a new `start`.
- R6: `mean_out` changes only on the edge that raises `mean_valid`. It holds its value during later runs until the next run completes.
- R7: `start` is ignored while a run is in progress. The result of that run is unchanged, and no second run is triggered.
- R8: Exactly one controller state is active at a time. `sample_taken` and `mean_valid` are never high together, and every `mean_valid` pulse directly follows a `sample_taken` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Requests a new run; sampled only while idle |
| sample_in | input | 8 | Current sample value from the source |
| sample_taken | output | 1 | One-cycle pulse: the current sample was consumed; present the next |
| mean_out | output | 8 | Registered mean of the last completed run |
| mean_valid | output | 1 | One-cycle pulse when `mean_out` is updated |

## Verification
The bench builds the block with its default parameters: 8-bit samples and sixteen per run. A sweep of constant sample sets then drives every one of the 256 output codes, including the all-0xFF maximum and the all-zero minimum. Random sets, a ramp, and a set whose sum of fifteen truncates to zero check the truncation rule of R2. Within those runs, a mid-run `start` pulse, a mid-run reset and a mid-run output check exercise R7, R1 and R6.

// File: rtl/avg_seq_pkg.sv
package avg_seq_pkg;

    localparam int NUM_ST   = 7;
    localparam int ST_IDLE  = 0;
    localparam int ST_CLEAR = 1;
    localparam int ST_DONE  = 2;
    localparam int ST_ADD   = 3;
    localparam int ST_WAIT  = 4;
    localparam int ST_ACK   = 5;
    localparam int ST_STEP  = 6;

    typedef logic [NUM_ST-1:0] onehot_t;

    typedef struct packed {
        logic clear;
        logic add;
        logic ack;
        logic step;
        logic done;
    } ctl_t;

endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
    import avg_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    last,
    output onehot_t state,
    output ctl_t    ctl
);

    typedef struct packed {
        onehot_t st;
    } reg_t;

    localparam onehot_t IDLE_CODE = onehot_t'(1) << ST_IDLE;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.st[ST_IDLE]  = (r_q.st[ST_IDLE] & ~start) | r_q.st[ST_DONE];
        r_d.st[ST_CLEAR] = r_q.st[ST_IDLE] & start;
        r_d.st[ST_ADD]   = r_q.st[ST_CLEAR] | r_q.st[ST_STEP];
        r_d.st[ST_WAIT]  = r_q.st[ST_ADD];
        r_d.st[ST_ACK]   = r_q.st[ST_WAIT];
        r_d.st[ST_STEP]  = r_q.st[ST_ACK] & ~last;
        r_d.st[ST_DONE]  = r_q.st[ST_ACK] & last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st <= IDLE_CODE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ctl.clear = r_q.st[ST_CLEAR];
        ctl.add   = r_q.st[ST_ADD];
        ctl.ack   = r_q.st[ST_ACK];
        ctl.step  = r_q.st[ST_STEP];
        ctl.done  = r_q.st[ST_DONE];
    end

    assign state = r_q.st;

endmodule

// File: rtl/avg_count.sv
module avg_count #(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam int CNT_W = (N > 2) ? $clog2(N) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.cnt = '0;
        end else if (step) begin
            r_d.cnt = r_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign last = (r_q.cnt == LAST_IDX);

endmodule

// File: rtl/avg_accum.sv
module avg_accum #(
    parameter int DATA_W = 8,
    parameter int LOG2_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              add,
    input  logic              load_out,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] mean
);

    localparam int SUM_W = DATA_W + LOG2_N;

    typedef struct packed {
        logic [SUM_W-1:0]  sum;
        logic [DATA_W-1:0] mean;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.sum = '0;
        end else if (add) begin
            r_d.sum = r_q.sum + SUM_W'(din);
        end
        if (load_out) begin
            r_d.mean = r_q.sum[SUM_W-1 -: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.sum  <= '0;
            r_q.mean <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mean = r_q.mean;

endmodule

// File: rtl/seq_averager.sv
module seq_averager
    import avg_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LOG2_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sample_taken,
    output logic [DATA_W-1:0] mean_out,
    output logic              mean_valid
);

    localparam int N = 1 << LOG2_N;

    onehot_t state_q;
    ctl_t    ctl;
    logic    last;

    avg_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .last  (last),
        .state (state_q),
        .ctl   (ctl)
    );

    avg_count #(.N(N)) u_count (
        .clk   (clk),
        .rst   (rst),
        .clear (ctl.clear),
        .step  (ctl.step),
        .last  (last)
    );

    avg_accum #(.DATA_W(DATA_W), .LOG2_N(LOG2_N)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .clear    (ctl.clear),
        .add      (ctl.add),
        .load_out (ctl.ack & last),
        .din      (sample_in),
        .mean     (mean_out)
    );

    assign sample_taken = ctl.ack;
    assign mean_valid   = ctl.done;

endmodule

// File: rtl/seq_averager_chk.sv
module seq_averager_chk
    import avg_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_taken,
    input logic              mean_valid,
    input logic [DATA_W-1:0] mean_out,
    input onehot_t           state
);

    AST_ONEHOT_STATE: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1); // R8

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(sample_taken && mean_valid)); // R8

    AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        mean_valid |-> $past(sample_taken)); // R8

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mean_valid |=> !mean_valid); // R5

    AST_MEAN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mean_valid |-> $stable(mean_out)); // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !state[ST_IDLE] |=> !state[ST_CLEAR]); // R7

endmodule

bind seq_averager seq_averager_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_taken (sample_taken),
    .mean_valid   (mean_valid),
    .mean_out     (mean_out),
    .state        (state_q)
);

// File: tb/tb_seq_averager.sv
module tb_seq_averager;

    localparam int DW = 8;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic          sample_taken;
    logic [DW-1:0] mean_out;
    logic          mean_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [DW-1:0] smp [NS];

    always #2 clk = ~clk;

    seq_averager dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .sample_in    (sample_in),
        .sample_taken (sample_taken),
        .mean_out     (mean_out),
        .mean_valid   (mean_valid)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One full run over smp[]; optionally pulses start mid-run (R7)
    task automatic do_run(input bit poke);
        int cyc = 0;
        int taken = 0;
        int sum = 0;
        bit done = 0;
        logic [DW-1:0] prev = mean_out;
        logic [DW-1:0] exp_mean;
        for (int i = 0; i < NS; i++) sum += smp[i];
        exp_mean = DW'(sum >> 4);
        @(negedge clk);
        sample_in = smp[0];
        start = 1'b1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
            if (poke && cyc == 20) start = 1'b1;
            if (poke && cyc == 21) start = 1'b0;
            if (cyc == 30) chk(mean_out == prev, "R6 mean holds mid-run", mean_out, prev);
            if (sample_taken) begin
                taken++;
                if (taken < NS) sample_in = smp[taken];
            end
            if (mean_valid) begin
                done = 1;
                chk(cyc == 4*NS + 1, "R4 valid timing", cyc, 4*NS + 1);
                chk(taken == NS, "R3 samples per run", taken, NS);
                chk(mean_out == exp_mean, poke ? "R7 busy start ignored" : "R2 mean value",
                    mean_out, exp_mean);
            end
        end
        chk(done, "R4 valid seen", done, 1);
        @(negedge clk);
        chk(!mean_valid, "R5 valid one cycle", mean_valid, 0);
        chk(mean_out == exp_mean, "R6 mean holds after valid", mean_out, exp_mean);
        begin
            int extra = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (sample_taken || mean_valid) extra++;
            end
            chk(extra == 0, poke ? "R7 no second run" : "R5 idle after run", extra, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mean_out == 0, "R1 reset mean", mean_out, 0);
        chk(!mean_valid, "R1 reset valid", mean_valid, 0);
        chk(!sample_taken, "R1 reset taken", sample_taken, 0);

        // All-0xFF: maximum sum 4080 -> 255
        for (int i = 0; i < NS; i++) smp[i] = 8'hFF;
        do_run(0);
        // Constant sweep: every output code
        for (int v = 0; v < 256; v++) begin
            for (int i = 0; i < NS; i++) smp[i] = DW'(v);
            do_run(0);
        end
        // Ramp 0..15: sum 120 -> 7 (truncation)
        for (int i = 0; i < NS; i++) smp[i] = DW'(i);
        do_run(0);
        // Sum 15 -> 0
        for (int i = 0; i < NS; i++) smp[i] = (i == 5) ? 8'd15 : 8'd0;
        do_run(0);
        // Random sets
        for (int r = 0; r < 24; r++) begin
            for (int i = 0; i < NS; i++) smp[i] = DW'($urandom_range(0, 255));
            do_run(r % 3 == 0);
        end

        // Mid-run reset (R1)
        for (int i = 0; i < NS; i++) smp[i] = 8'd200;
        @(negedge clk);
        sample_in = smp[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (25) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mean_out == 0, "R1 mid-run reset mean", mean_out, 0);
        chk(!mean_valid, "R1 mid-run reset valid", mean_valid, 0);
        begin
            int seen = 0;
            for (int k = 0; k < 80; k++) begin
                @(negedge clk);
                if (sample_taken || mean_valid) seen++;
            end
            chk(seen == 0, "R1 run abandoned", seen, 0);
        end
        do_run(0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule